// File: doc/BRIEF.md
# Addressed Bit Set/Clear Control Register

This block holds a sixteen-bit control word in which every bit is written on its own. A set strobe or a clear strobe, together with a four-bit subaddress, turns one chosen bit on or off and leaves the other fifteen bits untouched. A clear-all strobe, a bus initialise input and the power-up reset each empty the whole word in a single cycle. The low eight bits go straight out as two groups of four general-purpose isolated output drives, one group for each of two converter channels. The high eight bits form two four-bit control fields, one for each channel. Each field holds a polarity select, an increment enable, a decrement enable and a full-scale select.

The polarity bit chooses between unipolar straight-binary coding (0) and bipolar two's-complement coding (1). In both codings the most significant data bit is the top bit of the data word. A change to a channel's polarity or full-scale bit switches relays. For that reason the block raises a busy flag for that channel for a settling interval set by a parameter, with a default of 10 ms at 250 MHz. If either bit changes again during the interval, the interval starts over. Changes to the enable bits or to the output bits never raise the flag. The whole word can be read back with its bits numbered from 1, so the bit at subaddress x appears at readback position x+1.

Top module: `ctlreg_top`

## Requirements
- R1: A set strobe with subaddress x sets bit x and changes no other bit; the result shows on the next clock edge.
- R2: A clear strobe with subaddress x clears bit x and changes no other bit; the result shows on the next clock edge.
- R3: When the set strobe and the clear strobe arrive in the same cycle, the clear takes effect and the set is ignored.
- R4: The clear-all strobe or the bus initialise input zeroes all sixteen bits on the next edge and overrides any set or clear in that cycle. Reset also leaves the word at zero with both busy flags low.
- R5: Readback position n (1 to 16) shows register bit n-1, so a set at subaddress 6 appears at readback position 7.
- R6: Bits 0 to 3 drive the channel A outputs and bits 4 to 7 drive the channel B outputs. The outputs follow the register with no added cycle.
- R7: For channel A, bit 8 is polarity (1 = bipolar), bit 9 is increment enable, bit 10 is decrement enable and bit 11 is full-scale select (1 = half scale). Bits 12 to 15 hold the same fields for channel B. Each decoded output is bit 0 for channel A and bit 1 for channel B.
- R8: When a channel's polarity bit or full-scale bit changes, that channel's busy flag rises on the same edge that updates the register. It then stays high for exactly SETTLE_CYCLES cycles.
- R9: A further change to either of those bits while the flag is high restarts the full interval from the edge of that change.
- R10: Changes to enable bits, to output bits or to the other channel's bits do not raise a channel's busy flag.
- R11: Every set or clear strobe, for any of the sixteen subaddresses, is acknowledged by a one-cycle pulse on the edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| set_stb | input | 1 | Set the addressed bit |
| clr_stb | input | 1 | Clear the addressed bit |
| sub_addr | input | 4 | Bit select for set and clear |
| clr_all | input | 1 | Clear every bit |
| bus_init | input | 1 | Bus initialise; clears every bit |
| cmd_ack | output | 1 | Acknowledge, one cycle after a set or clear |
| rd_word | output | 16 | Readback word, positions 16 down to 1 |
| gpo_a | output | 4 | Channel A general-purpose outputs (bits 0-3) |
| gpo_b | output | 4 | Channel B general-purpose outputs (bits 4-7) |
| ch_bipolar | output | 2 | Polarity per channel |
| ch_inc_en | output | 2 | Front-panel increment enable per channel |
| ch_dec_en | output | 2 | Front-panel decrement enable per channel |
| ch_half_scale | output | 2 | Half-scale select per channel |
| range_busy | output | 2 | Relay settling busy per channel |

## Verification
Each strobe is held through one rising edge, and the outputs are sampled at the falling edge that follows it. At that point the readback word, the output pins, the decoded fields and the acknowledge all show the result, because each of them lies one register away from the strobe. The busy flag is counted at each falling edge from that first sample onward, and the count must equal the settling parameter exactly. The bench shortens that parameter so the count stays small. For the restart check, the second change is issued a known number of cycles into the first interval, and the count from that change must again reach the full interval. Cases that must not raise the flag are sampled in the cycle where the flag would first have risen, and for several cycles after it.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
    localparam int NBITS     = 16;
    localparam int SUB_W     = $clog2(NBITS);
    localparam int NCH       = 2;
    localparam int GP_PER_CH = 4;
    localparam int FLD_W     = 4;
    localparam int CTRL_BASE = NCH * GP_PER_CH;
    // field offsets inside one channel's control nibble
    localparam int F_POLAR   = 0;
    localparam int F_INC     = 1;
    localparam int F_DEC     = 2;
    localparam int F_HALF    = 3;

    typedef struct packed {
        logic [NBITS-1:0] bits;
        logic             ack;
    } bitfile_t;
endpackage

// File: rtl/ctlreg_bitfile.sv
module ctlreg_bitfile
    import ctlreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [SUB_W-1:0] sub_addr,
    input  logic             clr_all,
    input  logic             bus_init,
    output logic [NBITS-1:0] bits_d,
    output logic [NBITS-1:0] bits_q,
    output logic             ack_q
);
    bitfile_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ack = set_stb | clr_stb;
        if (clr_all || bus_init) begin
            st_d.bits = '0;
        end else begin
            if (set_stb) st_d.bits[sub_addr] = 1'b1;
            // clear evaluated last so it wins over a simultaneous set
            if (clr_stb) st_d.bits[sub_addr] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_d = st_d.bits;
    assign bits_q = st_q.bits;
    assign ack_q  = st_q.ack;
endmodule

// File: rtl/ctlreg_settle.sv
module ctlreg_settle
    import ctlreg_pkg::*;
#(
    parameter int SETTLE_CYCLES = 2_500_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] bits_d,
    input  logic [NBITS-1:0] bits_q,
    output logic [NCH-1:0]   busy
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam int POL = CTRL_BASE + ch * FLD_W + F_POLAR;
        localparam int HLF = CTRL_BASE + ch * FLD_W + F_HALF;

        logic [CNT_W-1:0] cnt_d, cnt_q;
        logic             relay_move;

        always_comb begin
            relay_move = (bits_d[POL] != bits_q[POL]) ||
                         (bits_d[HLF] != bits_q[HLF]);
            cnt_d = cnt_q;
            if (relay_move)
                cnt_d = CNT_LOAD;
            else if (cnt_q != '0)
                cnt_d = cnt_q - 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign busy[ch] = (cnt_q != '0);
    end
endmodule

// File: rtl/ctlreg_top.sv
module ctlreg_top
    import ctlreg_pkg::*;
#(
    parameter int SETTLE_CYCLES = 2_500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_stb,
    input  logic        clr_stb,
    input  logic [3:0]  sub_addr,
    input  logic        clr_all,
    input  logic        bus_init,
    output logic        cmd_ack,
    output logic [16:1] rd_word,
    output logic [3:0]  gpo_a,
    output logic [3:0]  gpo_b,
    output logic [1:0]  ch_bipolar,
    output logic [1:0]  ch_inc_en,
    output logic [1:0]  ch_dec_en,
    output logic [1:0]  ch_half_scale,
    output logic [1:0]  range_busy
);
    logic [NBITS-1:0] bits_d, bits_q;

    ctlreg_bitfile u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_stb  (set_stb),
        .clr_stb  (clr_stb),
        .sub_addr (sub_addr),
        .clr_all  (clr_all),
        .bus_init (bus_init),
        .bits_d   (bits_d),
        .bits_q   (bits_q),
        .ack_q    (cmd_ack)
    );

    ctlreg_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .bits_d (bits_d),
        .bits_q (bits_q),
        .busy   (range_busy)
    );

    // readback numbered from 1: position n carries bit n-1
    assign rd_word = bits_q;

    assign gpo_a = bits_q[GP_PER_CH-1:0];
    assign gpo_b = bits_q[2*GP_PER_CH-1:GP_PER_CH];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_fld
        localparam int B = CTRL_BASE + ch * FLD_W;
        assign ch_bipolar[ch]    = bits_q[B + F_POLAR];
        assign ch_inc_en[ch]     = bits_q[B + F_INC];
        assign ch_dec_en[ch]     = bits_q[B + F_DEC];
        assign ch_half_scale[ch] = bits_q[B + F_HALF];
    end
endmodule

// File: rtl/ctlreg_checks.sv
module ctlreg_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        set_stb,
    input logic        clr_stb,
    input logic [3:0]  sub_addr,
    input logic        clr_all,
    input logic        bus_init,
    input logic        cmd_ack,
    input logic [16:1] rd_word,
    input logic [1:0]  range_busy
);
    a_r1_set_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && !clr_stb && !clr_all && !bus_init)
        |=> (rd_word == ($past(rd_word) | (16'd1 << $past(sub_addr)))));

    a_r2_clear_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !clr_all && !bus_init)
        |=> (rd_word == ($past(rd_word) & ~(16'd1 << $past(sub_addr)))));

    a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all || bus_init) |=> (rd_word == 16'd0));

    a_r8_busy_a_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_word[9] != $past(rd_word[9])) || (rd_word[12] != $past(rd_word[12])))
        |-> range_busy[0]);

    a_r8_busy_b_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_word[13] != $past(rd_word[13])) || (rd_word[16] != $past(rd_word[16])))
        |-> range_busy[1]);

    a_r10_quiet_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(range_busy[0]) && $stable(rd_word[9]) && $stable(rd_word[12]))
        |-> !range_busy[0]);

    a_r10_quiet_b: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(range_busy[1]) && $stable(rd_word[13]) && $stable(rd_word[16]))
        |-> !range_busy[1]);

    a_r11_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb || clr_stb) |=> cmd_ack);
endmodule

bind ctlreg_top ctlreg_checks u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_stb    (set_stb),
    .clr_stb    (clr_stb),
    .sub_addr   (sub_addr),
    .clr_all    (clr_all),
    .bus_init   (bus_init),
    .cmd_ack    (cmd_ack),
    .rd_word    (rd_word),
    .range_busy (range_busy)
);

// File: tb/ctlreg_top_test.sv
`timescale 1ns/1ps
module ctlreg_top_test;
    localparam int SETTLE = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_stb = 1'b0, clr_stb = 1'b0, clr_all = 1'b0, bus_init = 1'b0;
    logic [3:0]  sub_addr = '0;
    logic        cmd_ack;
    logic [16:1] rd_word;
    logic [3:0]  gpo_a, gpo_b;
    logic [1:0]  ch_bipolar, ch_inc_en, ch_dec_en, ch_half_scale, range_busy;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ctlreg_top #(.SETTLE_CYCLES(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .clr_stb(clr_stb),
        .sub_addr(sub_addr), .clr_all(clr_all), .bus_init(bus_init),
        .cmd_ack(cmd_ack), .rd_word(rd_word), .gpo_a(gpo_a), .gpo_b(gpo_b),
        .ch_bipolar(ch_bipolar), .ch_inc_en(ch_inc_en), .ch_dec_en(ch_dec_en),
        .ch_half_scale(ch_half_scale), .range_busy(range_busy)
    );

    // {set, clear, subaddress, expected word (bit 0 = readback position 1)}
    localparam logic [21:0] VECS [12] = '{
        {1'b1, 1'b0, 4'd0,  16'h0001},
        {1'b1, 1'b0, 4'd6,  16'h0041},
        {1'b1, 1'b0, 4'd15, 16'h8041},
        {1'b1, 1'b0, 4'd9,  16'h8241},
        {1'b0, 1'b1, 4'd6,  16'h8201},
        {1'b0, 1'b1, 4'd3,  16'h8201},
        {1'b1, 1'b1, 4'd4,  16'h8201},
        {1'b1, 1'b0, 4'd4,  16'h8211},
        {1'b1, 1'b1, 4'd4,  16'h8201},
        {1'b1, 1'b0, 4'd12, 16'h9201},
        {1'b0, 1'b1, 4'd15, 16'h1201},
        {1'b0, 1'b1, 4'd0,  16'h1200}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive for one edge; returns at the falling edge after it
    task automatic cmd(input logic s, input logic c, input logic [3:0] a,
                       input logic ca, input logic bi);
        @(negedge clk);
        set_stb = s; clr_stb = c; sub_addr = a; clr_all = ca; bus_init = bi;
        @(negedge clk);
        set_stb = 0; clr_stb = 0; clr_all = 0; bus_init = 0;
    endtask

    task automatic wait_idle();
        while (range_busy != 2'b00) @(negedge clk);
    endtask

    task automatic count_busy(input int ch, output int n);
        n = 0;
        while (range_busy[ch] && n < 10 * SETTLE) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int n;
        repeat (3) @(negedge clk);
        // R4: reset state
        chk("R4 reset word", 32'(rd_word), 32'h0);
        chk("R4 reset busy", 32'(range_busy), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1 R2 R3 R5 R6 R11
        for (int i = 0; i < 12; i++) begin
            cmd(VECS[i][21], VECS[i][20], VECS[i][19:16], 1'b0, 1'b0);
            chk("R1/R2/R3/R5 word", 32'(rd_word), 32'(VECS[i][15:0]));
            chk("R6 gpo_a", 32'(gpo_a), 32'(VECS[i][3:0]));
            chk("R6 gpo_b", 32'(gpo_b), 32'(VECS[i][7:4]));
            chk("R11 ack", 32'(cmd_ack), 32'h1);
        end
        @(negedge clk);
        chk("R11 ack drops", 32'(cmd_ack), 32'h0);

        // R5: subaddress 6 appears at position 7
        cmd(1, 0, 4'd6, 0, 0);
        chk("R5 position 7", 32'(rd_word[7]), 32'h1);
        chk("R5 position 6", 32'(rd_word[6]), 32'h0);

        // R4: clear-all, then bus init overriding a set
        cmd(0, 0, 4'd0, 1, 0);
        chk("R4 clear-all", 32'(rd_word), 32'h0);
        wait_idle();
        cmd(1, 0, 4'd2, 0, 0);
        cmd(1, 0, 4'd3, 0, 1);
        chk("R4 bus init over set", 32'(rd_word), 32'h0);

        // R7: field decode
        cmd(1, 0, 4'd8,  0, 0);
        cmd(1, 0, 4'd11, 0, 0);
        cmd(1, 0, 4'd13, 0, 0);
        cmd(1, 0, 4'd14, 0, 0);
        chk("R7 bipolar", 32'(ch_bipolar), 32'h1);
        chk("R7 half scale", 32'(ch_half_scale), 32'h1);
        chk("R7 inc enable", 32'(ch_inc_en), 32'h2);
        chk("R7 dec enable", 32'(ch_dec_en), 32'h2);
        cmd(0, 0, 4'd0, 1, 0);
        wait_idle();
        repeat (2) @(negedge clk);

        // R10: enable and output bits do not start settling
        cmd(1, 0, 4'd9, 0, 0);
        chk("R10 inc enable no busy", 32'(range_busy), 32'h0);
        cmd(1, 0, 4'd1, 0, 0);
        chk("R10 output bit no busy", 32'(range_busy), 32'h0);
        cmd(1, 0, 4'd14, 0, 0);
        repeat (3) @(negedge clk);
        chk("R10 still idle", 32'(range_busy), 32'h0);

        // R8: polarity change on A, B unaffected
        cmd(1, 0, 4'd8, 0, 0);
        chk("R10 other channel", 32'(range_busy[1]), 32'h0);
        count_busy(0, n);
        chk("R8 interval length", 32'(n), 32'(SETTLE));

        // R9: restart on second change
        cmd(1, 0, 4'd11, 0, 0);
        repeat (4) @(negedge clk);
        cmd(0, 1, 4'd11, 0, 0);
        count_busy(0, n);
        chk("R9 restarted interval", 32'(n), 32'(SETTLE));

        // R8: channel B range bit
        cmd(1, 0, 4'd15, 0, 0);
        chk("R8 channel B rises", 32'(range_busy), 32'h2);
        count_busy(1, n);
        chk("R8 channel B length", 32'(n), 32'(SETTLE));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule